// File: doc/BRIEF.md
# Saturating Fractional Multiply-Accumulate Unit

The unit multiplies two signed Q15 operands and either places the product in, or adds it to, a 36-bit guarded accumulator. The four guard bits above the 32-bit product range let a long run of products build up before the sum wraps. The unit keeps two sticky overflow flags. One is set when the sum no longer fits a signed 32-bit range. The other is set when the full 36-bit addition overflows, or when the single product that cannot be represented occurs.

A controller issues one operation per cycle through `op_valid`, `op_code` and `op_data`. The operations load the operands, multiply, multiply-accumulate, clear, set the saturate mode, and read the accumulator. With saturate mode on and a flag set, a read returns the largest positive or largest negative 32-bit value, sign-extended to 36 bits, in place of the raw contents. The direction is fixed by the sign of the true sum at the first overflow. A read never alters the accumulator.

Top module: `sat_frac_mac`

## Requirements
- R1: After reset the accumulator is zero, both flags and `sat_mode` are 0, `done` is 0 and `rd_data` is 0.
- R2: Code 1 loads `op_data` into the multiplier and code 2 loads it into the multiplicand, each as a signed Q15 value.
- R3: Code 3 (multiply) replaces the accumulator with the product. The product is the 32-bit signed product shifted left by one and sign-extended to 36 bits. Both flags are first cleared and then set only by this product.
- R4: Code 4 (multiply-accumulate) adds the product to the accumulator, and the sum wraps modulo 2^36.
- R5: When both operands are 0x8000, the product is 0x7FFFFFFF and the accumulator-overflow flag is set.
- R6: `ext_ovf` is set when the accumulator after code 3 or 4 is outside the range -2^31..2^31-1. It stays set until code 3 or code 5.
- R7: `acc_ovf` is set when the 36-bit addition of code 4 overflows in two's complement. It stays set until code 3 or code 5.
- R8: Code 7 (read) loads `rd_data` with the 36-bit accumulator when saturate mode is off or both flags are clear. The accumulator is not changed by a read, and `rd_data` changes only on code 7.
- R9: A read with saturate mode on and a flag set returns 0x07FFFFFFF or 0xF80000000. It returns 0xF80000000 when the true, unwrapped sum was negative at the operation that first set a flag after they were both clear.
- R10: Code 5 zeroes the accumulator and both flags. Code 6 sets `sat_mode` to `op_data[0]`.
- R11: `done` is high exactly in the cycle after each accepted operation, for every code including 0 (no operation). All results appear in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation code (0 none, 1..7 as in requirements) |
| op_data | input | 16 | Operand or mode value |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 36 | Result of the last read |
| ext_ovf | output | 1 | Sticky 32-bit range overflow flag |
| acc_ovf | output | 1 | Sticky 36-bit overflow flag |
| sat_mode | output | 1 | Saturate mode state |

## Verification
The hardest state to reach is a true 36-bit addition overflow. Even full-scale products need seventeen accumulations in a row to wrap the guard bits. The stimulus therefore repeats multiply-accumulate with 0x7FFF×0x7FFF, and then with 0x8000×0x7FFF, well past that count. Reads are done with saturate mode both off and on, so the wrapped raw value and the clamp direction latched at the earlier 32-bit overflow are both checked. A long run of mixed operations then feeds the extreme operand values to a behavioural model that compares every output after every cycle.

// File: rtl/sat_frac_mac.sv
`timescale 1ns/1ps
module sat_frac_mac #(
  parameter int DW = 16,
  parameter int AW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [DW-1:0] op_data,
  output logic          done,
  output logic [AW-1:0] rd_data,
  output logic          ext_ovf,
  output logic          acc_ovf,
  output logic          sat_mode
);
  localparam int PW = 2 * DW;
  localparam int GW = AW - PW;
  localparam logic [2:0] OP_LDH = 3'd1, OP_LDI = 3'd2, OP_MUL = 3'd3,
                         OP_MAC = 3'd4, OP_CLR = 3'd5, OP_MODE = 3'd6,
                         OP_RD = 3'd7;
  localparam logic [DW-1:0] MIN_Q = {1'b1, {(DW-1){1'b0}}};
  localparam logic [AW-1:0] SAT_POS = {{(GW+1){1'b0}}, {(PW-1){1'b1}}};
  localparam logic [AW-1:0] SAT_NEG = {{(GW+1){1'b1}}, {(PW-1){1'b0}}};

  logic [DW-1:0] mpy, mcd;
  logic [AW-1:0] acc;
  logic          sgn;

  logic signed [PW-1:0] prod_raw;
  logic [PW-1:0] prod_q;
  logic [AW-1:0] prod_x, sum, nxt;
  logic          special, add_ovf, is_mul, is_mac, nxt_fits, new_ext, new_aov, prev_clr;

  assign prod_raw = $signed(mpy) * $signed(mcd);
  assign special  = (mpy == MIN_Q) && (mcd == MIN_Q);
  assign prod_q   = special ? {1'b0, {(PW-1){1'b1}}} : {prod_raw[PW-2:0], 1'b0};
  assign prod_x   = {{GW{prod_q[PW-1]}}, prod_q};
  assign sum      = acc + prod_x;
  assign add_ovf  = (acc[AW-1] == prod_x[AW-1]) && (sum[AW-1] != acc[AW-1]);
  assign is_mul   = op_valid && (op_code == OP_MUL);
  assign is_mac   = op_valid && (op_code == OP_MAC);
  assign nxt      = is_mul ? prod_x : sum;
  assign nxt_fits = (&nxt[AW-1:PW-1]) || ~(|nxt[AW-1:PW-1]);
  assign prev_clr = is_mul || (!ext_ovf && !acc_ovf);
  assign new_ext  = (is_mac && ext_ovf) || !nxt_fits;
  assign new_aov  = (is_mac && (acc_ovf || add_ovf)) || special;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpy <= '0; mcd <= '0; acc <= '0; sgn <= 1'b0;
      ext_ovf <= 1'b0; acc_ovf <= 1'b0; sat_mode <= 1'b0;
      rd_data <= '0; done <= 1'b0;
    end else begin
      done <= op_valid;
      if (op_valid) begin
        case (op_code)
          OP_LDH: mpy <= op_data;
          OP_LDI: mcd <= op_data;
          OP_MUL, OP_MAC: begin
            acc     <= nxt;
            ext_ovf <= new_ext;
            acc_ovf <= new_aov;
            if (prev_clr && (new_ext || new_aov))
              sgn <= (is_mac && add_ovf) ? acc[AW-1] : nxt[AW-1];
          end
          OP_CLR: begin
            acc <= '0; ext_ovf <= 1'b0; acc_ovf <= 1'b0;
          end
          OP_MODE: sat_mode <= op_data[0];
          OP_RD:
            rd_data <= (sat_mode && (ext_ovf || acc_ovf)) ? (sgn ? SAT_NEG : SAT_POS) : acc;
          default: ;
        endcase
      end
    end
  end

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) op_valid |=> done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !op_valid |=> !done); // R11
  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_CLR |=> !ext_ovf && !acc_ovf && acc == '0); // R10
  AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ovf && !(op_valid && (op_code == OP_CLR || op_code == OP_MUL)) |=> ext_ovf); // R6
  AST_ACC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ovf && !(op_valid && (op_code == OP_CLR || op_code == OP_MUL)) |=> acc_ovf); // R7
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_RD |=> $stable(acc)); // R8
  AST_MODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_MODE |=> sat_mode == $past(op_data[0])); // R10
  AST_SAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_RD && sat_mode && (ext_ovf || acc_ovf)
    |=> (rd_data == SAT_POS || rd_data == SAT_NEG)); // R9
  AST_SPECIAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_MUL || op_code == OP_MAC) && mpy == MIN_Q && mcd == MIN_Q
    |=> acc_ovf); // R5
endmodule

// File: tb/test_sat_frac_mac.sv
`timescale 1ns/1ps
module test_sat_frac_mac;
  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [15:0] op_data = 16'd0;
  logic done, ext_ovf, acc_ovf, sat_mode;
  logic [35:0] rd_data;

  sat_frac_mac i_sat_frac_mac (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_data(op_data), .done(done), .rd_data(rd_data), .ext_ovf(ext_ovf), .acc_ovf(acc_ovf),
    .sat_mode(sat_mode));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  longint m_acc = 0, m_h = 0, m_i = 0;
  logic m_ext = 0, m_aov = 0, m_sat = 0, m_dir = 0;
  logic [35:0] m_rd = '0;
  localparam longint LIM36 = 64'sd34359738368;
  localparam longint LIM32 = 64'sd2147483648;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] c, input logic [15:0] d);
    longint p, s, w;
    logic sp, ao, ex, pc;
    case (c)
      3'd1: m_h = longint'($signed(d));
      3'd2: m_i = longint'($signed(d));
      3'd3, 3'd4: begin
        sp = (m_h == -32768 && m_i == -32768);
        p = sp ? 64'sd2147483647 : m_h * m_i * 2;
        s = (c == 3'd4 ? m_acc : 64'sd0) + p;
        ao = (s >= LIM36) || (s < -LIM36);
        w = s;
        if (w >= LIM36) w = w - 2 * LIM36;
        if (w < -LIM36) w = w + 2 * LIM36;
        ex = (w >= LIM32) || (w < -LIM32);
        pc = (c == 3'd3) || (!m_ext && !m_aov);
        if (c == 3'd3) begin m_ext = 0; m_aov = 0; end
        m_ext = m_ext | ex;
        m_aov = m_aov | ao | sp;
        if (pc && (m_ext || m_aov)) m_dir = (s < 0);
        m_acc = w;
      end
      3'd5: begin m_acc = 0; m_ext = 0; m_aov = 0; end
      3'd6: m_sat = d[0];
      3'd7: m_rd = (m_sat && (m_ext || m_aov)) ? (m_dir ? 36'hF80000000 : 36'h07FFFFFFF) : m_acc[35:0];
      default: ;
    endcase
  endtask

  task automatic run(input logic [2:0] c, input logic [15:0] d);
    string t;
    op_valid = 1'b1; op_code = c; op_data = d;
    @(negedge clk);
    model(c, d);
    op_valid = 1'b0;
    case (c)
      3'd1, 3'd2: t = "R2";
      3'd3: t = "R3";
      3'd4: t = "R4";
      3'd5, 3'd6: t = "R10";
      3'd7: t = (m_sat && (m_ext || m_aov)) ? "R9" : "R8";
      default: t = "R11";
    endcase
    chk("R11 done", done, 1);
    chk({t, " ext_ovf R6"}, ext_ovf, m_ext);
    chk({t, " acc_ovf R7"}, acc_ovf, m_aov);
    chk({t, " sat_mode"}, sat_mode, m_sat);
    chk({t, " rd_data"}, rd_data, m_rd);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0); chk("R1 ext_ovf", ext_ovf, 0); chk("R1 acc_ovf", acc_ovf, 0);
    chk("R1 sat_mode", sat_mode, 0); chk("R1 rd_data", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(3'd7, 0);
    // R3 0.5*0.5 = 0x20000000
    run(3'd1, 16'h4000); run(3'd2, 16'h4000); run(3'd3, 0); run(3'd7, 0);
    chk("R3 quarter", rd_data, 36'h020000000);
    // R4 add negative product
    run(3'd1, 16'hC000); run(3'd4, 0); run(3'd7, 0);
    chk("R4 back to zero", rd_data, 0);
    // R11 idle cycle and no-op leave state alone
    @(negedge clk); chk("R11 idle", done, 0);
    run(3'd0, 0); run(3'd7, 0);
    // R5 -1*-1
    run(3'd1, 16'h8000); run(3'd2, 16'h8000); run(3'd3, 0); run(3'd7, 0);
    chk("R5 clamp", rd_data, 36'h07FFFFFFF); chk("R5 flag", acc_ovf, 1);
    run(3'd6, 1); run(3'd7, 0);
    run(3'd5, 0); run(3'd7, 0);
    chk("R10 clear", rd_data, 0);
    // R6 positive 32-bit overflow, raw then saturated
    run(3'd6, 0);
    run(3'd1, 16'h7FFF); run(3'd2, 16'h7FFF); run(3'd3, 0); run(3'd4, 0); run(3'd7, 0);
    chk("R6 raw", rd_data, 36'h0FFFC0004);
    run(3'd6, 1); run(3'd7, 0);
    chk("R9 pos", rd_data, 36'h07FFFFFFF);
    // R7 36-bit wrap after many full-scale MACs
    for (int k = 0; k < 18; k++) run(3'd4, 0);
    chk("R7 flag", acc_ovf, 1);
    run(3'd7, 0); run(3'd6, 0); run(3'd7, 0);
    // R9 negative direction
    run(3'd5, 0); run(3'd6, 1);
    run(3'd1, 16'h8000); run(3'd2, 16'h7FFF);
    for (int k = 0; k < 20; k++) begin run(3'd4, 0); run(3'd7, 0); end
    chk("R9 neg", rd_data, 36'hF80000000);
    run(3'd6, 0); run(3'd7, 0);
    run(3'd3, 0); run(3'd7, 0);
    // mixed stress
    for (int k = 0; k < 2000; k++) begin
      logic [2:0] c;
      logic [15:0] d;
      c = 3'($urandom_range(0, 7));
      if (c == 3'd5 && $urandom_range(0, 3) != 0) c = 3'd4;
      case ($urandom_range(0, 3))
        0: d = 16'h8000;
        1: d = 16'h7FFF;
        default: d = 16'($urandom);
      endcase
      run(c, d);
    end
    summary();
  end
endmodule